// File: doc/BRIEF.md
# Timer Channel Access Safety Monitor

One of these monitors sits beside each channel of a timer/counter peripheral. It watches the register bus of that channel: a valid strobe, a write flag and a byte offset. It sorts suspicious software accesses into typed codes. It also captures writes that hit protected registers while write protection is on. It flags a counter that has run past its compare value while compare-reset should have stopped it. It latches a pulse from an external clock-glitch detector.

Each finding is held in a sticky slot. The slots are gathered into one read-only 32-bit status word, which resets to zero. Reading that word through the bus clears every slot at the next clock edge. An event that arrives in the same cycle as the read is kept for the next read.

Each sticky slot is a two-state machine. SLOT_EMPTY moves to SLOT_HELD when its event occurs (transition CAPTURE). In SLOT_HELD, a new event reloads the payload and the slot stays held (transition REFRESH). A status read with no new event returns the slot to SLOT_EMPTY (transition RELEASE). With neither an event nor a read, either state holds its value (transition IDLE_HOLD).

The channel register window uses these offsets and attributes:

| Offset | Attribute | Protected |
|---|---|---|
| 0x00 | write-only command | no |
| 0x04 | mode, read-write | yes |
| 0x10 | counter, read-only | no |
| 0x14 | capture A / compare A, read-write | yes |
| 0x18 | capture B / compare B, read-write | yes |
| 0x1C | period compare (RC), read-write | yes |
| 0x20 | channel status, read-only | no |
| 0x24 | interrupt enable, write-only | no |
| 0x38 | this status word, read-only | no |

Every other offset is undefined.

Top module: `tc_safety_monitor`

## Requirements
- R1: After reset the status word is 0x00000000. Bits 30:28 and 7:4 always read zero.
- R2: A read of a write-only offset (0x00 or 0x24) while `chan_en`=1 sets bit 3 and loads type 0 into bits 27:24. The same read with `chan_en`=0 changes nothing.
- R3: A write to a read-only offset (0x10, 0x20 or 0x38) while `chan_en`=1 sets bit 3 and loads type 1 into bits 27:24.
- R4: Any access to an undefined offset, read or write and whatever the value of `chan_en`, sets bit 3 and loads type 2.
- R5: A write to 0x14 or 0x18 while `chan_en`=1 and `capture_mode`=1 sets bit 3 and loads type 3. With `capture_mode`=0 the same write raises nothing.
- R6: Bit 31 is 1 when the stored type is 3 and 0 when it is 0, 1 or 2.
- R7: A write to a protected offset while `wp_en`=1 sets bit 0 and stores the zero-extended offset in bits 23:8. A write while `wp_en`=0, or a write to an unprotected offset, leaves bits 23:8 and 0 unchanged.
- R8: Bit 2 is set when `clk_started`=1, `capture_mode`=0, `rc_trig_en`=1 and `cnt_val` > `rc_val` (unsigned). When the two values are equal, bit 2 is not set.
- R9: A one-cycle `glitch_pulse` sets bit 1.
- R10: A bus read of offset 0x38 clears every field, including bit 31, at the next edge.
- R11: An event that occurs in the same cycle as a status read is present in the word after that read.
- R12: When several software errors, or several protected writes, happen between reads, the word holds the most recent one.
- R13: A read of offset 0x38 never raises a software error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access strobe for this channel |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset inside the channel window |
| chan_en | input | 1 | Channel enabled |
| capture_mode | input | 1 | 1 = capture mode, 0 = waveform mode |
| clk_started | input | 1 | Channel counter clock running |
| rc_trig_en | input | 1 | Counter reset on RC compare enabled |
| wp_en | input | 1 | Write protection active |
| cnt_val | input | CNT_W | Current counter value |
| rc_val | input | CNT_W | RC compare value |
| glitch_pulse | input | 1 | One-cycle clock-glitch indication |
| status_word | output | 32 | Sticky safety status word |

## Verification
The assertions assume that `bus_addr` and the qualifiers carry known values, with no X, while the monitor is out of reset. They also assume that at most one access is presented per cycle, so that one offset decides the software error type. The stimulus drives every input at the falling edge from a fixed-seed generator. It draws offsets mostly from the defined window plus the undefined offset 0x3C, and sometimes picks a fully random byte. Glitch pulses are a single cycle wide, and counter and compare values are chosen so that both the over-compare and the equal cases occur.

// File: rtl/tc_safe_pkg.sv
package tc_safe_pkg;

    localparam int STAT_W = 32;
    localparam int VIOL_W = 16;
    localparam int TYPE_W = 4;

    typedef enum logic [2:0] {
        ATTR_UNDEF,
        ATTR_RW,
        ATTR_RO,
        ATTR_WO,
        ATTR_SELF
    } attr_kind_e;

    typedef struct packed {
        attr_kind_e kind;
        logic       prot;
        logic       capt_ref;
    } reg_attr_t;

    typedef enum logic [TYPE_W-1:0] {
        SWT_RD_WO   = 4'd0,
        SWT_WR_RO   = 4'd1,
        SWT_UNDEF   = 4'd2,
        SWT_CAPT_WR = 4'd3
    } sw_type_e;

    typedef enum logic {
        SLOT_EMPTY,
        SLOT_HELD
    } slot_state_e;

    // channel window byte offsets
    localparam logic [VIOL_W-1:0] OFS_CMD   = 16'h0000;
    localparam logic [VIOL_W-1:0] OFS_MODE  = 16'h0004;
    localparam logic [VIOL_W-1:0] OFS_CNT   = 16'h0010;
    localparam logic [VIOL_W-1:0] OFS_CAPA  = 16'h0014;
    localparam logic [VIOL_W-1:0] OFS_CAPB  = 16'h0018;
    localparam logic [VIOL_W-1:0] OFS_PER   = 16'h001C;
    localparam logic [VIOL_W-1:0] OFS_CSTAT = 16'h0020;
    localparam logic [VIOL_W-1:0] OFS_IEN   = 16'h0024;
    localparam logic [VIOL_W-1:0] OFS_SAFE  = 16'h0038;

    function automatic reg_attr_t attr_of(input logic [VIOL_W-1:0] ofs);
        reg_attr_t a;
        a = '{kind: ATTR_UNDEF, prot: 1'b0, capt_ref: 1'b0};
        case (ofs)
            OFS_CMD:   a.kind = ATTR_WO;
            OFS_MODE:  begin a.kind = ATTR_RW; a.prot = 1'b1; end
            OFS_CNT:   a.kind = ATTR_RO;
            OFS_CAPA:  begin a.kind = ATTR_RW; a.prot = 1'b1; a.capt_ref = 1'b1; end
            OFS_CAPB:  begin a.kind = ATTR_RW; a.prot = 1'b1; a.capt_ref = 1'b1; end
            OFS_PER:   begin a.kind = ATTR_RW; a.prot = 1'b1; end
            OFS_CSTAT: a.kind = ATTR_RO;
            OFS_IEN:   a.kind = ATTR_WO;
            OFS_SAFE:  a.kind = ATTR_SELF;
            default:   a.kind = ATTR_UNDEF;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/tc_access_classify.sv
module tc_access_classify
    import tc_safe_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              chan_en,
    input  logic              capture_mode,
    input  logic              wp_en,
    output logic              sw_hit,
    output logic [TYPE_W-1:0] sw_type,
    output logic              sw_class,
    output logic              wp_hit,
    output logic [VIOL_W-1:0] wp_ofs,
    output logic              stat_rd
);

    logic [VIOL_W-1:0] ofs;
    reg_attr_t         attr;
    sw_type_e          kind_code;

    always_comb begin
        ofs  = VIOL_W'(bus_addr);
        attr = attr_of(ofs);
    end

    // software error sorting: one access per cycle gives one type
    always_comb begin
        sw_hit    = 1'b0;
        kind_code = SWT_UNDEF;
        if (bus_valid) begin
            unique case (attr.kind)
                ATTR_UNDEF: begin
                    sw_hit    = 1'b1;
                    kind_code = SWT_UNDEF;
                end
                ATTR_WO: begin
                    if (!bus_write && chan_en) begin
                        sw_hit    = 1'b1;
                        kind_code = SWT_RD_WO;
                    end
                end
                ATTR_RO, ATTR_SELF: begin
                    if (bus_write && chan_en) begin
                        sw_hit    = 1'b1;
                        kind_code = SWT_WR_RO;
                    end
                end
                ATTR_RW: begin
                    if (bus_write && chan_en && capture_mode && attr.capt_ref) begin
                        sw_hit    = 1'b1;
                        kind_code = SWT_CAPT_WR;
                    end
                end
                default: sw_hit = 1'b0;
            endcase
        end
    end

    always_comb begin
        sw_type  = kind_code;
        sw_class = (kind_code == SWT_CAPT_WR);
        wp_hit   = bus_valid && bus_write && wp_en && attr.prot;
        wp_ofs   = ofs;
        stat_rd  = bus_valid && !bus_write && (attr.kind == ATTR_SELF);
    end

endmodule

// File: rtl/tc_seq_check.sv
module tc_seq_check #(
    parameter int CNT_W = 16
) (
    input  logic             clk_started,
    input  logic             capture_mode,
    input  logic             rc_trig_en,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] rc_val,
    output logic             seq_err
);

    logic armed;

    always_comb begin
        armed   = clk_started && !capture_mode && rc_trig_en;
        seq_err = armed && (cnt_val > rc_val);
    end

endmodule

// File: rtl/tc_sticky_slot.sv
module tc_sticky_slot
    import tc_safe_pkg::*;
#(
    parameter int PAY_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic [PAY_W-1:0] pay_i,
    input  logic             clr_i,
    output logic [PAY_W-1:0] data_o
);

    slot_state_e      state_q, state_d;
    logic [PAY_W-1:0] pay_q;

    // next-state: CAPTURE, REFRESH, RELEASE, IDLE_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (set_i) state_d = SLOT_HELD;
            SLOT_HELD: begin
                if (set_i)      state_d = SLOT_HELD;
                else if (clr_i) state_d = SLOT_EMPTY;
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
            pay_q   <= '0;
        end else begin
            state_q <= state_d;
            if (set_i)
                pay_q <= pay_i;
            else if (clr_i)
                pay_q <= '0;
        end
    end

    always_comb begin
        data_o = (state_q == SLOT_HELD) ? pay_q : '0;
    end

endmodule

// File: rtl/tc_safety_monitor.sv
module tc_safety_monitor
    import tc_safe_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              chan_en,
    input  logic              capture_mode,
    input  logic              clk_started,
    input  logic              rc_trig_en,
    input  logic              wp_en,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic [CNT_W-1:0]  rc_val,
    input  logic              glitch_pulse,
    output logic [STAT_W-1:0] status_word
);

    localparam int SW_PAY_W = TYPE_W + 2;
    localparam int WP_PAY_W = VIOL_W + 1;
    localparam int N_FLAG   = 2;

    logic              sw_hit, sw_class, wp_hit, stat_rd, seq_err;
    logic [TYPE_W-1:0] sw_type;
    logic [VIOL_W-1:0] wp_ofs;
    logic [SW_PAY_W-1:0] sw_data;
    logic [WP_PAY_W-1:0] wp_data;
    logic [N_FLAG-1:0]   flag_set, flag_q;

    tc_access_classify #(.ADDR_W(ADDR_W)) u_classify (
        .bus_valid    (bus_valid),
        .bus_write    (bus_write),
        .bus_addr     (bus_addr),
        .chan_en      (chan_en),
        .capture_mode (capture_mode),
        .wp_en        (wp_en),
        .sw_hit       (sw_hit),
        .sw_type      (sw_type),
        .sw_class     (sw_class),
        .wp_hit       (wp_hit),
        .wp_ofs       (wp_ofs),
        .stat_rd      (stat_rd)
    );

    tc_seq_check #(.CNT_W(CNT_W)) u_seq (
        .clk_started  (clk_started),
        .capture_mode (capture_mode),
        .rc_trig_en   (rc_trig_en),
        .cnt_val      (cnt_val),
        .rc_val       (rc_val),
        .seq_err      (seq_err)
    );

    // software error record: {flag, class, type}
    tc_sticky_slot #(.PAY_W(SW_PAY_W)) u_sw_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (sw_hit),
        .pay_i  ({1'b1, sw_class, sw_type}),
        .clr_i  (stat_rd),
        .data_o (sw_data)
    );

    // protection violation record: {flag, offset}
    tc_sticky_slot #(.PAY_W(WP_PAY_W)) u_wp_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (wp_hit),
        .pay_i  ({1'b1, wp_ofs}),
        .clr_i  (stat_rd),
        .data_o (wp_data)
    );

    // single-bit flags: index 0 glitch, index 1 sequencer
    assign flag_set = {seq_err, glitch_pulse};

    generate
        for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
            tc_sticky_slot #(.PAY_W(1)) u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (flag_set[g]),
                .pay_i  (1'b1),
                .clr_i  (stat_rd),
                .data_o (flag_q[g])
            );
        end
    endgenerate

    always_comb begin
        status_word        = '0;
        status_word[31]    = sw_data[TYPE_W];
        status_word[27:24] = sw_data[TYPE_W-1:0];
        status_word[23:8]  = wp_data[VIOL_W-1:0];
        status_word[3]     = sw_data[TYPE_W+1];
        status_word[2]     = flag_q[1];
        status_word[1]     = flag_q[0];
        status_word[0]     = wp_data[VIOL_W];
    end

endmodule

// File: rtl/tc_safety_monitor_chk.sv
module tc_safety_monitor_chk #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              capture_mode,
    input logic              clk_started,
    input logic              rc_trig_en,
    input logic [CNT_W-1:0]  cnt_val,
    input logic [CNT_W-1:0]  rc_val,
    input logic              glitch_pulse,
    input logic [31:0]       status_word
);

    // R1
    spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[30:28] == 3'b0) && (status_word[7:4] == 4'b0));

    // R6
    class_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[31] |-> (status_word[27:24] == 4'd3));

    // R10
    sw_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status_word[3] |-> (status_word[31:24] == 8'h00));

    // R7
    viol_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status_word[0] |-> (status_word[23:8] == 16'h0000));

    // R9
    glitch_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        glitch_pulse |=> status_word[1]);

    // R8
    seq_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_started && !capture_mode && rc_trig_en && (cnt_val > rc_val)) |=> status_word[2]);

    // R4
    undef_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && (bus_addr == ADDR_W'(8'h3C))) |=> (status_word[3] && (status_word[27:24] == 4'd2)));

    // R13
    self_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && (bus_addr == ADDR_W'(8'h38)) && !glitch_pulse)
        |=> (!status_word[3] && !status_word[1]));

endmodule

bind tc_safety_monitor tc_safety_monitor_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_valid    (bus_valid),
    .bus_write    (bus_write),
    .bus_addr     (bus_addr),
    .capture_mode (capture_mode),
    .clk_started  (clk_started),
    .rc_trig_en   (rc_trig_en),
    .cnt_val      (cnt_val),
    .rc_val       (rc_val),
    .glitch_pulse (glitch_pulse),
    .status_word  (status_word)
);

// File: tb/tb_tc_safety_monitor.sv
module tb_tc_safety_monitor;

    localparam int ADDR_W = 8;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              bus_valid, bus_write;
    logic [ADDR_W-1:0] bus_addr;
    logic              chan_en, capture_mode, clk_started, rc_trig_en, wp_en;
    logic [CNT_W-1:0]  cnt_val, rc_val;
    logic              glitch_pulse;
    logic [31:0]       status_word;

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    logic [31:0] exp_word;

    always #5 clk = ~clk;

    tc_safety_monitor #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .chan_en(chan_en), .capture_mode(capture_mode),
        .clk_started(clk_started), .rc_trig_en(rc_trig_en), .wp_en(wp_en),
        .cnt_val(cnt_val), .rc_val(rc_val), .glitch_pulse(glitch_pulse),
        .status_word(status_word)
    );

    function automatic bit a_wo(input logic [7:0] a);
        return a == 8'h00 || a == 8'h24;
    endfunction
    function automatic bit a_ro(input logic [7:0] a);
        return a == 8'h10 || a == 8'h20 || a == 8'h38;
    endfunction
    function automatic bit a_prot(input logic [7:0] a);
        return a == 8'h04 || a == 8'h14 || a == 8'h18 || a == 8'h1C;
    endfunction
    function automatic bit a_def(input logic [7:0] a);
        return a_wo(a) || a_ro(a) || a_prot(a);
    endfunction

    // expected word after the coming edge, from the requirements
    function automatic logic [31:0] ref_next(input logic [31:0] cur);
        logic [31:0] w;
        bit hit;
        logic [3:0] ty;
        w   = (bus_valid && !bus_write && bus_addr == 8'h38) ? 32'h0 : cur;
        hit = 1'b0;
        ty  = 4'd0;
        if (bus_valid) begin
            if (!a_def(bus_addr)) begin hit = 1; ty = 4'd2; end
            else if (a_wo(bus_addr) && !bus_write && chan_en) begin hit = 1; ty = 4'd0; end
            else if (a_ro(bus_addr) && bus_write && chan_en) begin hit = 1; ty = 4'd1; end
            else if ((bus_addr == 8'h14 || bus_addr == 8'h18) && bus_write && chan_en && capture_mode) begin
                hit = 1; ty = 4'd3;
            end
        end
        if (hit) begin
            w[31]    = (ty == 4'd3);
            w[27:24] = ty;
            w[3]     = 1'b1;
        end
        if (bus_valid && bus_write && wp_en && a_prot(bus_addr)) begin
            w[23:8] = {8'h00, bus_addr};
            w[0]    = 1'b1;
        end
        if (clk_started && !capture_mode && rc_trig_en && cnt_val > rc_val) w[2] = 1'b1;
        if (glitch_pulse) w[1] = 1'b1;
        return w;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: status_word actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic acc(input bit v, input bit w, input logic [7:0] a);
        bus_valid = v; bus_write = w; bus_addr = a;
    endtask

    // apply current inputs for one edge, then compare at the falling edge
    task automatic step(input string tag);
        exp_word = ref_next(exp_word);
        @(posedge clk);
        @(negedge clk);
        check(tag, status_word, exp_word);
        bus_valid = 1'b0; bus_write = 1'b0; glitch_pulse = 1'b0;
    endtask

    task automatic lit(input string tag, input logic [31:0] v);
        check(tag, status_word, v);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5A5A));
        rst_n = 1'b0; acc(0, 0, 8'h00);
        chan_en = 0; capture_mode = 0; clk_started = 0; rc_trig_en = 0; wp_en = 0;
        cnt_val = '0; rc_val = '0; glitch_pulse = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        lit("R1 reset", 32'h0000_0000);
        rst_n = 1'b1;
        exp_word = 32'h0;

        // R2 write-only read while enabled, then disabled
        chan_en = 1; acc(1, 0, 8'h00); step("R2 read wo");
        lit("R2 type0", 32'h0000_0008);
        acc(1, 0, 8'h38); step("R10 clear");
        lit("R10 cleared", 32'h0);
        chan_en = 0; acc(1, 0, 8'h24); step("R2 disabled no effect");
        lit("R2 disabled", 32'h0);

        // R3 then R4 overwriting (R12)
        chan_en = 1; acc(1, 1, 8'h10); step("R3 write ro");
        lit("R3 type1", 32'h0100_0008);
        chan_en = 0; acc(1, 1, 8'h3C); step("R4 undefined");
        lit("R12 latest type", 32'h0200_0008);
        acc(1, 0, 8'h38); step("R10 clear");

        // R5 / R6 capture-mode write, then waveform write ignored
        chan_en = 1; capture_mode = 1; acc(1, 1, 8'h14); step("R5 capture write");
        lit("R6 class error", 32'h8300_0008);
        capture_mode = 0; acc(1, 1, 8'h18); step("R5 waveform no effect");
        lit("R5 unchanged", 32'h8300_0008);
        acc(1, 0, 8'h38); step("R10 class cleared");
        lit("R10 class", 32'h0);

        // R7 protection
        chan_en = 0; wp_en = 1; acc(1, 1, 8'h1C); step("R7 protected write");
        lit("R7 offset", 32'h0000_1C01);
        acc(1, 1, 8'h04); step("R12 latest offset");
        lit("R12 offset", 32'h0000_0401);
        acc(1, 0, 8'h38); step("R10 clear");
        wp_en = 0; acc(1, 1, 8'h14); step("R7 wp off no effect");
        lit("R7 off", 32'h0);

        // R8 sequencer
        clk_started = 1; rc_trig_en = 1; cnt_val = 16'd100; rc_val = 16'd100;
        step("R8 equal no flag");
        lit("R8 equal", 32'h0);
        cnt_val = 16'd101; step("R8 over compare");
        lit("R8 flag", 32'h0000_0004);
        clk_started = 0; acc(1, 0, 8'h38); step("R10 clear");

        // R9 glitch, R11 event with read
        glitch_pulse = 1; step("R9 glitch");
        lit("R9 flag", 32'h0000_0002);
        glitch_pulse = 1; acc(1, 0, 8'h38); step("R11 event wins");
        lit("R11 kept", 32'h0000_0002);
        chan_en = 1; acc(1, 0, 8'h38); step("R13 self read");
        lit("R13 no error", 32'h0);

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] pick [10];
            pick = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h38, 8'h3C};
            bus_valid    = ($urandom % 4) != 0;
            bus_write    = $urandom % 2;
            bus_addr     = (($urandom % 8) == 0) ? 8'($urandom) : pick[$urandom % 10];
            chan_en      = $urandom % 2;
            capture_mode = $urandom % 2;
            clk_started  = ($urandom % 4) == 0;
            rc_trig_en   = $urandom % 2;
            wp_en        = $urandom % 2;
            rc_val       = 16'($urandom % 64);
            cnt_val      = (($urandom % 4) == 0) ? rc_val : 16'($urandom % 64);
            glitch_pulse = ($urandom % 8) == 0;
            step("R12 random mix");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule